// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block puts a register port for a CPU in front of a small one-time-programmable fuse array. The array is modelled as flip-flops that reset to all zeros. Software picks a command and a row address, loads up to two write-data words, and launches the command by setting a start bit. It then polls a status register until a completion flag appears, and clears start before it issues the next command. Rows hold either one or two 32-bit words; a parameter chooses which.

Programming is locked after reset. To unlock it, software runs four unlock-step commands, each a full start/complete cycle, with the key words 0xF, 0x4, 0x8 and 0xD in that order. When the fourth step completes, the program-enabled flag is set. A lock command clears the flag again. A program command ORs the write data into the addressed row, because a fuse bit can only go from 0 to 1. Each command kind has its own latency, set by a parameter.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: The byte offsets are 0x00 access-grant (bit 0), 0x04 command (6 bits), 0x08 start (bit 0), 0x0C status, 0x10 read word 0, 0x28 row address (16 bits), 0x2C write word 0, 0x5C read word 1 and 0x64 write word 1. The command, address, access-grant and write registers read back what was written, with the upper bits dropped.
- R2: While access-grant bit 0 is clear, writing start to 1 launches nothing, and the status register stays unchanged.
- R3: A command launches when start goes from 0 to 1 by a register write. Status bit 1 (done) rises exactly READ_LAT cycles later, or PROG_LAT cycles later for a program command. Writing start to 0 clears done in the next cycle.
- R4: Command 0x00 (read) copies the addressed row into the read-word registers. Read word 1 holds the second word of the row when rows have two words, and reads as zero otherwise.
- R5: Four completed commands of code 0x02 (unlock step) carrying write word 0 values 0xF, 0x4, 0x8, 0xD in order set status bit 2 (program enabled) at the completion of the fourth.
- R6: An unlock step whose key does not match the expected one returns the sequence to its first step, so a full correct run of four is needed again.
- R7: Command 0x08 (program) completes with done when programming is not enabled, but it leaves the array unchanged.
- R8: When programming is enabled, a program command sets each stored word to its old value OR the matching write word, for every word of the row.
- R9: Command 0x03 (lock) completes with done and clears status bit 2.
- R10: The command code, row address and write words are captured at launch. Register writes made while the command is still running do not affect it.
- R11: A command code with no defined meaning completes with done, and it changes neither the array nor status bit 2.
- R12: The row is selected by the low log2(NUM_ROWS) bits of the address register, so addresses that differ only above those bits reach the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | REG_AW | Register byte offset for both reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |

## Verification
Two things can land on the same clock edge: the engine finishing a command, and the CPU writing a new address and new write data into the registers the command was launched from. The bench provokes this by rewriting the address in the last cycle of a program command and the write word on the very edge the command completes. It then reads back the launched row and the decoy row, and compares them with a bench model that applies only the values captured at launch. In a second case, the unlock tracker and the engine finish together on the fourth key, and the bench checks that the program-enabled flag is visible in the same cycle that done is.

// File: rtl/otp_fuse_pkg.sv
// Package: shared offsets, command codes and unlock keys for the fuse controller.
// Assumes: a byte-addressed register window of at most 256 bytes.
package otp_fuse_pkg;

    localparam int WORD_W = 32;
    localparam int CMD_W  = 6;
    localparam int ROWA_W = 16;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFS_GRANT = 8'h00;
    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_START = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_RD0   = 8'h10;
    localparam logic [7:0] OFS_ROW   = 8'h28;
    localparam logic [7:0] OFS_WD0   = 8'h2C;
    localparam logic [7:0] OFS_RD1   = 8'h5C;
    localparam logic [7:0] OFS_WD1   = 8'h64;

    // Command codes.
    localparam logic [CMD_W-1:0] OP_READ   = 6'h00;
    localparam logic [CMD_W-1:0] OP_UNLOCK = 6'h02;
    localparam logic [CMD_W-1:0] OP_LOCK   = 6'h03;
    localparam logic [CMD_W-1:0] OP_BURN   = 6'h08;

    localparam int KEY_STEPS = 4;

    // Key expected at each unlock step, in order.
    function automatic logic [WORD_W-1:0] unlock_key(input logic [1:0] idx);
        case (idx)
            2'd0:    return 32'h0000_000F;
            2'd1:    return 32'h0000_0004;
            2'd2:    return 32'h0000_0008;
            default: return 32'h0000_000D;
        endcase
    endfunction

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_BUSY = 2'd1,
        ENG_DONE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/otp_regs.sv
// Module: register window of the fuse controller. It holds the CPU-written
// registers, decodes the start handshake into launch/halt pulses and muxes
// the read data. Assumes: at most one write per cycle, and reads are
// combinational from the address.
module otp_regs
    import otp_fuse_pkg::*;
#(
    parameter int ROW_WORDS = 2,
    parameter int REG_AW    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [REG_AW-1:0]                 bus_addr,
    input  logic [WORD_W-1:0]                 bus_wdata,
    output logic [WORD_W-1:0]                 bus_rdata,
    input  logic                              eng_idle,
    input  logic                              done,
    input  logic                              prog_ok,
    input  logic [ROW_WORDS-1:0][WORD_W-1:0]  rd_words,
    output logic                              launch,
    output logic                              halt,
    output logic                              grant,
    output logic [CMD_W-1:0]                  cmd,
    output logic [ROWA_W-1:0]                 row_addr,
    output logic [ROW_WORDS-1:0][WORD_W-1:0]  wr_words
);

    logic              grant_q;
    logic              start_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [ROWA_W-1:0] row_q;
    logic [WORD_W-1:0] wd0_q;
    logic [WORD_W-1:0] hi_wd;
    logic [WORD_W-1:0] hi_rd;
    logic [7:0]        ofs;
    logic              wr_start;

    assign ofs      = 8'(bus_addr);
    assign wr_start = bus_wr && (ofs == OFS_START);

    // Register writes for the single-instance fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            start_q <= 1'b0;
            cmd_q   <= '0;
            row_q   <= '0;
            wd0_q   <= '0;
        end else if (bus_wr) begin
            case (ofs)
                OFS_GRANT: grant_q <= bus_wdata[0];
                OFS_CMD:   cmd_q   <= bus_wdata[CMD_W-1:0];
                OFS_START: start_q <= bus_wdata[0];
                OFS_ROW:   row_q   <= bus_wdata[ROWA_W-1:0];
                OFS_WD0:   wd0_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // The second word exists only in two-word rows.
    generate
        if (ROW_WORDS > 1) begin : g_two_word
            logic [WORD_W-1:0] wd1_q;

            // Register write for the second write word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    wd1_q <= '0;
                else if (bus_wr && ofs == OFS_WD1)
                    wd1_q <= bus_wdata;
            end

            assign hi_wd    = wd1_q;
            assign hi_rd    = rd_words[ROW_WORDS-1];
            assign wr_words = {wd1_q, wd0_q};
        end else begin : g_one_word
            assign hi_wd    = '0;
            assign hi_rd    = '0;
            assign wr_words = wd0_q;
        end
    endgenerate

    // Start handshake: a 0->1 write with access granted and the engine idle.
    assign launch = wr_start && bus_wdata[0] && !start_q && grant_q && eng_idle;
    assign halt   = wr_start && !bus_wdata[0];

    assign grant    = grant_q;
    assign cmd      = cmd_q;
    assign row_addr = row_q;

    // Read-data multiplexer.
    always_comb begin
        case (ofs)
            OFS_GRANT: bus_rdata = {31'd0, grant_q};
            OFS_CMD:   bus_rdata = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
            OFS_START: bus_rdata = {31'd0, start_q};
            OFS_STAT:  bus_rdata = {29'd0, prog_ok, done, 1'b0};
            OFS_RD0:   bus_rdata = rd_words[0];
            OFS_ROW:   bus_rdata = {{(WORD_W-ROWA_W){1'b0}}, row_q};
            OFS_WD0:   bus_rdata = wd0_q;
            OFS_RD1:   bus_rdata = hi_rd;
            OFS_WD1:   bus_rdata = hi_wd;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/otp_unlock.sv
// Module: unlock tracker. It follows the four-key sequence across completed
// unlock-step commands and holds the program-enabled flag. Assumes: "finish"
// pulses once per completed command, with the launched code and key stable.
module otp_unlock
    import otp_fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic [CMD_W-1:0]  cmd_s,
    input  logic [WORD_W-1:0] key_s,
    output logic              prog_ok
);

    localparam int STEP_W = $clog2(KEY_STEPS);

    logic [STEP_W-1:0] step_q;

    // Advance, restart or complete the key sequence; a lock command clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            prog_ok <= 1'b0;
        end else if (finish) begin
            if (cmd_s == OP_UNLOCK) begin
                if (key_s == unlock_key(step_q)) begin
                    if (step_q == STEP_W'(KEY_STEPS-1)) begin
                        prog_ok <= 1'b1;
                        step_q  <= '0;
                    end else begin
                        step_q  <= step_q + 1'b1;
                    end
                end else begin
                    step_q <= '0;
                end
            end else if (cmd_s == OP_LOCK) begin
                prog_ok <= 1'b0;
                step_q  <= '0;
            end
        end
    end

endmodule

// File: rtl/otp_engine.sv
// Module: command engine and fuse array. It captures the command at launch,
// counts the latency that belongs to the command kind, then reads or burns
// the addressed row and raises done. Assumes: NUM_ROWS is a power of two,
// both latencies are at least 2, and ROW_WORDS is 1 or 2.
module otp_engine
    import otp_fuse_pkg::*;
#(
    parameter int NUM_ROWS  = 32,
    parameter int ROW_WORDS = 2,
    parameter int READ_LAT  = 3,
    parameter int PROG_LAT  = 10
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     launch,
    input  logic                                     halt,
    input  logic [CMD_W-1:0]                         cmd,
    input  logic [ROWA_W-1:0]                        row_addr,
    input  logic [ROW_WORDS-1:0][WORD_W-1:0]         wr_words,
    input  logic                                     prog_ok,
    output logic                                     eng_idle,
    output logic                                     done,
    output logic                                     finish,
    output logic [CMD_W-1:0]                         cmd_s,
    output logic [WORD_W-1:0]                        key_s,
    output logic [ROW_WORDS-1:0][WORD_W-1:0]         rd_words,
    output logic [NUM_ROWS*ROW_WORDS*WORD_W-1:0]     fuse_bits
);

    localparam int RIDX_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int LAT_MAX = (PROG_LAT > READ_LAT) ? PROG_LAT : READ_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam logic [CNT_W-1:0] RD_RELOAD = CNT_W'(READ_LAT - 1);
    localparam logic [CNT_W-1:0] PG_RELOAD = CNT_W'(PROG_LAT - 1);

    eng_state_e                          state_q;
    logic [CNT_W-1:0]                    cnt_q;
    logic [RIDX_W-1:0]                   row_s;
    logic [ROW_WORDS-1:0][WORD_W-1:0]    wd_s;
    logic [NUM_ROWS-1:0][ROW_WORDS-1:0][WORD_W-1:0] fuse_q;

    assign eng_idle  = (state_q == ENG_IDLE);
    assign finish    = (state_q == ENG_BUSY) && (cnt_q == '0) && !halt;
    assign key_s     = wd_s[0];
    assign fuse_bits = fuse_q;

    // Command FSM: capture at launch, count down, hold done until start clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
            cmd_s   <= '0;
            row_s   <= '0;
            wd_s    <= '0;
        end else if (halt) begin
            state_q <= ENG_IDLE;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: if (launch) begin
                    state_q <= ENG_BUSY;
                    cmd_s   <= cmd;
                    row_s   <= row_addr[RIDX_W-1:0];
                    wd_s    <= wr_words;
                    cnt_q   <= (cmd == OP_BURN) ? PG_RELOAD : RD_RELOAD;
                end
                ENG_BUSY: if (cnt_q == '0) begin
                    state_q <= ENG_DONE;
                    done    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Array access on completion: read copies a row, an enabled burn ORs into it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q   <= '0;
            rd_words <= '0;
        end else if (finish) begin
            if (cmd_s == OP_READ)
                rd_words <= fuse_q[row_s];
            if (cmd_s == OP_BURN && prog_ok)
                fuse_q[row_s] <= fuse_q[row_s] | wd_s;
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl.sv
// Module: top of the fuse controller. It wires the register window, the
// command engine and the unlock tracker together. Assumes: a single clock,
// a synchronous active-low reset, and a CPU that follows the start/done
// handshake.
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int NUM_ROWS  = 32,
    parameter int ROW_WORDS = 2,
    parameter int READ_LAT  = 3,
    parameter int PROG_LAT  = 10,
    parameter int REG_AW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic                                 launch;
    logic                                 halt;
    logic                                 grant;
    logic                                 eng_idle;
    logic                                 done;
    logic                                 finish;
    logic                                 prog_ok;
    logic [CMD_W-1:0]                     cmd;
    logic [CMD_W-1:0]                     cmd_s;
    logic [ROWA_W-1:0]                    row_addr;
    logic [WORD_W-1:0]                    key_s;
    logic [ROW_WORDS-1:0][WORD_W-1:0]     wr_words;
    logic [ROW_WORDS-1:0][WORD_W-1:0]     rd_words;
    logic [NUM_ROWS*ROW_WORDS*WORD_W-1:0] fuse_bits;

    otp_regs #(
        .ROW_WORDS (ROW_WORDS),
        .REG_AW    (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_idle  (eng_idle),
        .done      (done),
        .prog_ok   (prog_ok),
        .rd_words  (rd_words),
        .launch    (launch),
        .halt      (halt),
        .grant     (grant),
        .cmd       (cmd),
        .row_addr  (row_addr),
        .wr_words  (wr_words)
    );

    otp_engine #(
        .NUM_ROWS  (NUM_ROWS),
        .ROW_WORDS (ROW_WORDS),
        .READ_LAT  (READ_LAT),
        .PROG_LAT  (PROG_LAT)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .halt      (halt),
        .cmd       (cmd),
        .row_addr  (row_addr),
        .wr_words  (wr_words),
        .prog_ok   (prog_ok),
        .eng_idle  (eng_idle),
        .done      (done),
        .finish    (finish),
        .cmd_s     (cmd_s),
        .key_s     (key_s),
        .rd_words  (rd_words),
        .fuse_bits (fuse_bits)
    );

    otp_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .cmd_s   (cmd_s),
        .key_s   (key_s),
        .prog_ok (prog_ok)
    );

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
// Module: assertion checker for the fuse controller, bound into the top.
// Assumes: it sees the top's internal handshake, engine and array signals.
module otp_fuse_ctrl_chk
    import otp_fuse_pkg::*;
#(
    parameter int NUM_ROWS  = 32,
    parameter int ROW_WORDS = 2,
    parameter int READ_LAT  = 3,
    parameter int PROG_LAT  = 10
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 launch,
    input logic                                 halt,
    input logic                                 grant,
    input logic                                 eng_idle,
    input logic                                 done,
    input logic                                 finish,
    input logic                                 prog_ok,
    input logic [CMD_W-1:0]                     cmd_s,
    input logic [NUM_ROWS*ROW_WORDS*WORD_W-1:0] fuse_bits
);

    logic [15:0] since_q;
    logic [15:0] need;

    // Count the cycles since the last launch, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '0;
        else if (launch)
            since_q <= '0;
        else if (since_q != 16'hFFFF)
            since_q <= since_q + 1'b1;
    end

    assign need = (cmd_s == OP_BURN) ? 16'(PROG_LAT) : 16'(READ_LAT);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (since_q >= need));

    assert_done_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !done);

    assert_grant_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && eng_idle) |=> eng_idle);

    assert_enable_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_ok) |-> $past(finish && cmd_s == OP_UNLOCK));

    assert_fuse_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fuse_bits) & ~fuse_bits) == '0));

    assert_locked_no_burn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_ok |=> $stable(fuse_bits));

    assert_lock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && cmd_s == OP_LOCK) |=> !prog_ok);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .NUM_ROWS  (NUM_ROWS),
    .ROW_WORDS (ROW_WORDS),
    .READ_LAT  (READ_LAT),
    .PROG_LAT  (PROG_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .halt      (halt),
    .grant     (grant),
    .eng_idle  (eng_idle),
    .done      (done),
    .finish    (finish),
    .prog_ok   (prog_ok),
    .cmd_s     (cmd_s),
    .fuse_bits (fuse_bits)
);

// File: tb/otp_fuse_ctrl_test.sv
// Bench: directed corner cases plus seeded random commands. Every result is
// compared with a bench-side model of the array and the unlock tracker.
module otp_fuse_ctrl_test;

    localparam int NUM_ROWS = 32;
    localparam int READ_LAT = 3;
    localparam int PROG_LAT = 10;

    localparam logic [7:0] A_GRANT = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
                           A_STAT = 8'h0C, A_RD0 = 8'h10, A_ROW = 8'h28,
                           A_WD0 = 8'h2C, A_RD1 = 8'h5C, A_WD1 = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mm [NUM_ROWS][2];
    bit          m_ok;
    int          m_step;

    otp_fuse_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] key_of(input int s);
        case (s)
            0: return 32'hF;
            1: return 32'h4;
            2: return 32'h8;
            default: return 32'hD;
        endcase
    endfunction

    // Model of completion effects, taken from the requirements.
    task automatic model(input logic [5:0] op, input int row, input logic [31:0] d0, input logic [31:0] d1);
        if (op == 6'h02) begin
            if (d0 == key_of(m_step)) begin
                if (m_step == 3) begin m_ok = 1'b1; m_step = 0; end
                else m_step++;
            end else m_step = 0;
        end else if (op == 6'h03) begin
            m_ok = 1'b0; m_step = 0;
        end else if (op == 6'h08 && m_ok) begin
            mm[row][0] = mm[row][0] | d0;
            mm[row][1] = mm[row][1] | d1;
        end
    endtask

    // Run one command through the full handshake and check its outcome.
    task automatic run_cmd(input logic [5:0] op, input logic [15:0] adr, input logic [31:0] d0,
                           input logic [31:0] d1, input bit disturb, input string tag);
        logic [31:0] v;
        int lat;
        int row;
        lat = (op == 6'h08) ? PROG_LAT : READ_LAT;
        row = int'(adr) % NUM_ROWS;
        wr(A_CMD, {26'd0, op});
        wr(A_ROW, {16'd0, adr});
        wr(A_WD0, d0);
        wr(A_WD1, d1);
        wr(A_START, 32'h1);
        if (disturb) begin
            repeat (lat - 2) @(negedge clk);
            rd(A_STAT, v); chk({tag, " R3 early"}, v & 32'h2, 32'h0);
            wr(A_ROW, {16'd0, adr ^ 16'h0005});
            wr(A_WD0, ~d0);
        end else begin
            repeat (lat - 1) @(negedge clk);
            rd(A_STAT, v); chk({tag, " R3 early"}, v & 32'h2, 32'h0);
            @(negedge clk);
        end
        model(op, row, d0, d1);
        rd(A_STAT, v);
        chk({tag, " R3 done"}, v, {29'd0, m_ok, 1'b1, 1'b0});
        if (op == 6'h00) begin
            rd(A_RD0, v); chk({tag, " R4 word0"}, v, mm[row][0]);
            rd(A_RD1, v); chk({tag, " R4 word1"}, v, mm[row][1]);
        end
        wr(A_START, 32'h0);
        rd(A_STAT, v);
        chk({tag, " R3 clear"}, v & 32'h2, 32'h0);
    endtask

    task automatic unlock4(input logic [31:0] k0, k1, k2, k3, input string tag);
        run_cmd(6'h02, 16'h0, k0, 32'h0, 1'b0, tag);
        run_cmd(6'h02, 16'h0, k1, 32'h0, 1'b0, tag);
        run_cmd(6'h02, 16'h0, k2, 32'h0, 1'b0, tag);
        run_cmd(6'h02, 16'h0, k3, 32'h0, 1'b0, tag);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        for (int r = 0; r < NUM_ROWS; r++) begin mm[r][0] = '0; mm[r][1] = '0; end
        m_ok = 1'b0; m_step = 0;
        seed = $urandom(32'h0D15_EA5E);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state and register readback with field masking (R1).
        rd(A_STAT, v);  chk("R1 reset status", v, 32'h0);
        rd(A_GRANT, v); chk("R1 reset grant", v, 32'h0);
        rd(A_RD0, v);   chk("R1 reset read word", v, 32'h0);
        wr(A_CMD, 32'hFFFF_FFFF); rd(A_CMD, v); chk("R1 command mask", v, 32'h3F);
        wr(A_ROW, 32'hFFFF_FFFF); rd(A_ROW, v); chk("R1 address mask", v, 32'hFFFF);
        wr(A_WD1, 32'h1234_5678); rd(A_WD1, v); chk("R1 write word 1", v, 32'h1234_5678);
        wr(A_GRANT, 32'hFFFF_FFFF); rd(A_GRANT, v); chk("R1 grant", v, 32'h1);

        // Start with access not granted is ignored (R2).
        wr(A_GRANT, 32'h0);
        wr(A_CMD, 32'h0);
        wr(A_START, 32'h1);
        repeat (PROG_LAT + 4) @(negedge clk);
        rd(A_STAT, v); chk("R2 no launch", v, 32'h0);
        wr(A_START, 32'h0);
        wr(A_GRANT, 32'h1);

        // Burn while locked completes but changes nothing (R7).
        run_cmd(6'h08, 16'd3, 32'hA5A5_0000, 32'h0000_5A5A, 1'b0, "R7 locked burn");
        run_cmd(6'h00, 16'd3, 32'h0, 32'h0, 1'b0, "R7 readback");

        // Correct unlock (R5), then two burns OR together (R8).
        unlock4(32'hF, 32'h4, 32'h8, 32'hD, "R5 unlock");
        rd(A_STAT, v); chk("R5 enabled", v & 32'h4, 32'h4);
        run_cmd(6'h08, 16'd3, 32'h0000_00F0, 32'h8000_0000, 1'b0, "R8 burn a");
        run_cmd(6'h08, 16'd3, 32'h0F00_000F, 32'h0000_0001, 1'b0, "R8 burn b");
        run_cmd(6'h00, 16'd3, 32'h0, 32'h0, 1'b0, "R8 readback");
        rd(A_RD0, v); chk("R8 OR word0", v, 32'h0F00_00FF);
        rd(A_RD1, v); chk("R8 OR word1", v, 32'h8000_0001);

        // High address bits alias the same row (R12).
        run_cmd(6'h00, 16'd3 + 16'(NUM_ROWS), 32'h0, 32'h0, 1'b0, "R12 alias");
        rd(A_RD0, v); chk("R12 alias word0", v, 32'h0F00_00FF);

        // Register writes during a running burn do not affect it (R10).
        run_cmd(6'h08, 16'd5, 32'hCAFE_0001, 32'h0BAD_0002, 1'b1, "R10 disturbed burn");
        run_cmd(6'h00, 16'd5, 32'h0, 32'h0, 1'b0, "R10 launched row");
        run_cmd(6'h00, 16'd0, 32'h0, 32'h0, 1'b0, "R10 decoy row");
        rd(A_RD0, v); chk("R10 decoy untouched", v, 32'h0);

        // Undefined code only completes (R11).
        run_cmd(6'h05, 16'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R11 undefined");
        run_cmd(6'h00, 16'd5, 32'h0, 32'h0, 1'b0, "R11 readback");

        // Lock clears the flag, and a later burn is blocked (R9).
        run_cmd(6'h03, 16'd0, 32'h0, 32'h0, 1'b0, "R9 lock");
        rd(A_STAT, v); chk("R9 disabled", v & 32'h4, 32'h0);
        run_cmd(6'h08, 16'd7, 32'hFFFF_FFFF, 32'h1, 1'b0, "R9 burn after lock");
        run_cmd(6'h00, 16'd7, 32'h0, 32'h0, 1'b0, "R9 readback");

        // Wrong keys restart the sequence (R6).
        unlock4(32'hF, 32'h4, 32'h9, 32'hD, "R6 bad third");
        rd(A_STAT, v); chk("R6 still locked", v & 32'h4, 32'h0);
        run_cmd(6'h02, 16'h0, 32'hF, 32'h0, 1'b0, "R6 repeat key");
        unlock4(32'hF, 32'h4, 32'h8, 32'hD, "R6 after restart");
        unlock4(32'hF, 32'h4, 32'h8, 32'hD, "R5 full again");
        rd(A_STAT, v); chk("R5 enabled again", v & 32'h4, 32'h4);

        // Seeded random mix (R4 R5 R6 R7 R8 R9 R10).
        for (int i = 0; i < 150; i++) begin
            int op;
            logic [15:0] a;
            logic [31:0] d0, d1;
            op = int'($urandom_range(0, 5));
            a  = 16'($urandom);
            d0 = $urandom & $urandom;
            d1 = $urandom & $urandom;
            case (op)
                0: run_cmd(6'h00, a, d0, d1, 1'b0, "R4 random read");
                1: run_cmd(6'h08, a, d0, d1, i[0], "R8 random burn");
                2: unlock4(32'hF, 32'h4, 32'h8, 32'hD, "R5 random unlock");
                3: unlock4(32'hF, ($urandom_range(0, 1) != 0) ? 32'h4 : 32'h3, 32'h8, 32'hD, "R6 random unlock");
                4: run_cmd(6'h03, a, d0, d1, 1'b0, "R9 random lock");
                default: run_cmd(6'h02, a, key_of(m_step), d1, 1'b0, "R5 random step");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule